// File: doc/BRIEF.md
# Prescaled Timer and Interrupt Controller

This block keeps a 32-bit count that advances once for every 128 cycles of the core clock. Beside it sits a compare register, and when the count steps onto the stored compare value an interrupt source is raised. Status is gathered in a pending register, and each bit of that register is cleared when software writes a 1 to it. An enable mask decides which pending bits reach the single interrupt line to the processor.

Two front-panel button inputs feed fixed status positions. The power button sets bit 11 (mask 0x800) and the reset button sets bit 17 (mask 0x20000). Every other status position except bit 0 is driven by a generic event input. Each raw input passes through a two-flop synchroniser and a rising-edge detector before it sets its bit. Software reaches the registers through a plain 32-bit read/write strobe bus that uses a word index.

Top module: `tmr_irq_top`

## Requirements
- R1: After a synchronous reset, the count, compare, pending and enable registers all read 0 and `irq_o` is low.
- R2: When nothing is written, the count increases by exactly 1 once every 128 clock cycles and wraps from 0xFFFFFFFF to 0.
- R3: Writing the count register (word index 0) loads the written value and restarts the divide-by-128 stage, so the next increment happens 128 cycles after the write edge.
- R4: Pending bit 0 is set on the clock edge where the count advances to a value equal to the compare register (word index 1), and this happens only after the compare register has been written at least once since reset.
- R5: While the count stays equal to the compare value, clearing pending bit 0 leaves it clear.
- R6: Writing the pending register (word index 2) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: A rising edge on `btn_pwr_i` sets pending bit 11 and a rising edge on `btn_rst_i` sets pending bit 17, three clock edges after the input changes. Holding an input high does not set the bit again after it has been cleared.
- R8: A rising edge on `evt_i[n]` sets pending bit n for every n other than 0, 11 and 17. `evt_i` bits 0, 11 and 17 have no effect.
- R9: One cycle after the pending and enable registers change, `irq_o` equals the OR of (pending AND enable), where enable is word index 3.
- R10: When a hardware set and a write-1-to-clear hit the same pending bit on the same edge, the bit ends up set.
- R11: A read strobe returns the addressed register on `bus_rdata_o` after the next clock edge. Word indices 0 to 3 are count, compare, pending and enable. Other indices read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| btn_rst_i | input | 1 | Reset button, asynchronous level |
| btn_pwr_i | input | 1 | Power button, asynchronous level |
| evt_i | input | 32 | Generic asynchronous event levels, one per pending bit |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
A wrong count or prescaler phase shows up at the ports as a read value that is off by one count. It also moves the alarm bit by a whole multiple of 128 cycles, so the bench compares every read against a behavioural model on every clock, and the first read after the drift exposes it. A corrupted pending or enable bit reaches `irq_o` one cycle later and appears in the next pending read. A synchroniser or edge detector that fires twice, or fires on a level, shows up as a bit that comes back after it has been cleared. The same-edge set-and-clear collision is placed deliberately on a known edge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_COUNT   = 0;
  localparam int REG_COMPARE = 1;
  localparam int REG_PENDING = 2;
  localparam int REG_ENABLE  = 3;

  // pending positions with fixed hardware sources
  localparam int BIT_ALARM = 0;
  localparam int BIT_PWR   = 11;
  localparam int BIT_RST   = 17;

  typedef struct packed {
    logic count;
    logic compare;
    logic pending;
    logic enable;
  } reg_sel_t;
endpackage

// File: rtl/tmr_prescale_counter.sv
module tmr_prescale_counter #(
  parameter int W   = 32,
  parameter int DIV = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o,
  output logic         step_o
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [W-1:0]     cnt_q;
  logic             wrap_pre;

  assign wrap_pre = (pre_q == PRE_MAX);
  assign step_o   = wrap_pre && !load_i;
  assign next_o   = cnt_q + W'(1);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= load_val_i;
    end else if (wrap_pre) begin
      pre_q <= '0;
      cnt_q <= next_o;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assert_load_restart_R3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_o == $past(load_val_i)) && (pre_q == '0));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_o) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_alarm_cmp.sv
module tmr_alarm_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] alarm_o,
  output logic         hit_o
);
  logic [W-1:0] alarm_q;
  logic         armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_i) begin
      alarm_q <= wdata_i;
      armed_q <= 1'b1;
    end
  end

  // only the advancing edge compares, so a held equality fires once
  assign hit_o   = step_i && armed_q && (next_i == alarm_q);
  assign alarm_o = alarm_q;

  assert_arm_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> armed_q && (alarm_o == $past(wdata_i)));

  assert_hit_single_R5: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q && !s3_q;
  end

  assert_rise_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_data_i,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] enable_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, en_q, clr_eff, pend_d;
  logic         irq_q;

  assign clr_eff = clr_wr_i ? clr_mask_i : '0;
  assign pend_d  = (pend_q & ~clr_eff) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_wr_i) en_q <= en_data_i;
      irq_q  <= |(pend_q & en_q);
    end
  end

  assign pending_o = pend_q;
  assign enable_o  = en_q;
  assign irq_o     = irq_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pending_o & $past(set_i)) == $past(set_i)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((pending_o & enable_o) == '0) |=> !irq_o);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (|(pending_o & enable_o)) |=> irq_o);

  assert_clear_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_wr_i) |=> ((pending_o & $past(pending_o)) == $past(pending_o)));
endmodule

// File: rtl/tmr_irq_top.sv
module tmr_irq_top
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIV    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              btn_rst_i,
  input  logic              btn_pwr_i,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] FIXED_MASK =
    (DATA_W'(1) << BIT_ALARM) | (DATA_W'(1) << BIT_PWR) | (DATA_W'(1) << BIT_RST);

  reg_sel_t wsel, rsel;
  logic [DATA_W-1:0] cnt, nxt, alarm, pending, enable;
  logic [DATA_W-1:0] raw, rise, set_vec, rd_mux, rdata_q;
  logic step, hit;

  always_comb begin
    wsel = '0;
    rsel = '0;
    if (bus_we_i) begin
      wsel.count   = (bus_addr_i == ADDR_W'(REG_COUNT));
      wsel.compare = (bus_addr_i == ADDR_W'(REG_COMPARE));
      wsel.pending = (bus_addr_i == ADDR_W'(REG_PENDING));
      wsel.enable  = (bus_addr_i == ADDR_W'(REG_ENABLE));
    end
    rsel.count   = (bus_addr_i == ADDR_W'(REG_COUNT));
    rsel.compare = (bus_addr_i == ADDR_W'(REG_COMPARE));
    rsel.pending = (bus_addr_i == ADDR_W'(REG_PENDING));
    rsel.enable  = (bus_addr_i == ADDR_W'(REG_ENABLE));
  end

  tmr_prescale_counter #(.W(DATA_W), .DIV(DIV)) u_cnt (
    .clk(clk), .rst(rst),
    .load_i(wsel.count), .load_val_i(bus_wdata_i),
    .cnt_o(cnt), .next_o(nxt), .step_o(step)
  );

  tmr_alarm_cmp #(.W(DATA_W)) u_alarm (
    .clk(clk), .rst(rst),
    .wr_i(wsel.compare), .wdata_i(bus_wdata_i),
    .step_i(step), .next_i(nxt),
    .alarm_o(alarm), .hit_o(hit)
  );

  // generic events fill every position not owned by a fixed source
  for (genvar i = 0; i < DATA_W; i++) begin : g_raw
    if (i == BIT_PWR) begin : g_pwr
      assign raw[i] = btn_pwr_i;
    end else if (i == BIT_RST) begin : g_rst
      assign raw[i] = btn_rst_i;
    end else begin : g_gen
      assign raw[i] = evt_i[i] & ~FIXED_MASK[i];
    end
  end

  irq_edge_sync #(.N(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .raw_i(raw), .rise_o(rise)
  );

  assign set_vec = rise | (hit ? (DATA_W'(1) << BIT_ALARM) : '0);

  irq_status_regs #(.N(DATA_W)) u_stat (
    .clk(clk), .rst(rst),
    .set_i(set_vec),
    .clr_wr_i(wsel.pending), .clr_mask_i(bus_wdata_i),
    .en_wr_i(wsel.enable), .en_data_i(bus_wdata_i),
    .pending_o(pending), .enable_o(enable), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rsel.count)   rd_mux = cnt;
    if (rsel.compare) rd_mux = alarm;
    if (rsel.pending) rd_mux = pending;
    if (rsel.enable)  rd_mux = enable;
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_re_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_re_i |=> $stable(bus_rdata_o));

  assert_alarm_sets_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> pending[BIT_ALARM]);
endmodule

// File: tb/tmr_irq_top_tb.sv
module tmr_irq_top_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, evt = '0;
  logic        btn_rst = 1'b0, btn_pwr = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  tmr_irq_top u_dut (
    .clk(clk), .rst(rst), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .btn_rst_i(btn_rst),
    .btn_pwr_i(btn_pwr), .evt_i(evt), .irq_o(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_timer, m_alarm, m_pend, m_en, m_rdata, m_s1, m_s2, m_s3;
  int          m_pre;
  bit          m_armed, m_irq;

  always @(posedge clk) begin : model
    logic [31:0] rawv, risev, clrv, setv;
    bit tick, load, hit;
    if (rst) begin
      m_timer = 0; m_alarm = 0; m_pend = 0; m_en = 0; m_rdata = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_armed = 0; m_irq = 0;
    end else begin
      rawv = evt & ~32'h0002_0801;
      rawv[11] = btn_pwr;
      rawv[17] = btn_rst;
      risev = m_s2 & ~m_s3;
      load = we && (addr == 0);
      tick = (m_pre == 127);
      hit  = tick && !load && m_armed && ((m_timer + 32'd1) == m_alarm);
      setv = risev;
      if (hit) setv[0] = 1'b1;
      clrv = (we && addr == 2) ? wdata : 32'd0;
      if (re) begin
        case (addr)
          4'd0: m_rdata = m_timer;
          4'd1: m_rdata = m_alarm;
          4'd2: m_rdata = m_pend;
          4'd3: m_rdata = m_en;
          default: m_rdata = 0;
        endcase
      end
      m_irq  = |(m_pend & m_en);
      m_pend = (m_pend & ~clrv) | setv;
      if (we && addr == 3) m_en = wdata;
      if (we && addr == 1) begin m_alarm = wdata; m_armed = 1; end
      if (load) begin m_timer = wdata; m_pre = 0; end
      else if (tick) begin m_timer = m_timer + 32'd1; m_pre = 0; end
      else m_pre = m_pre + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = rawv;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      chk("R11 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'd0, v); chk("R1 count", v, 0);
    rd(4'd1, v); chk("R1 compare", v, 0);
    rd(4'd2, v); chk("R1 pending", v, 0);
    rd(4'd3, v); chk("R1 enable", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(4'd7, v); chk("R11 unmapped read", v, 0);

    // R4 unarmed: wrap onto compare value 0 sets nothing; R2 wrap
    wr(4'd0, 32'hFFFF_FFFF);
    waitn(130);
    rd(4'd2, v); chk("R4 unarmed no alarm", v, 0);
    rd(4'd0, v); chk("R2 wrap to zero", v, 0);

    // R3 load and prescaler restart, R2 single step
    wr(4'd0, 32'd100);
    waitn(126);
    rd(4'd0, v); chk("R3 loaded value", v, 100);
    rd(4'd0, v); chk("R3 no early step", v, 100);
    rd(4'd0, v); chk("R2 step after 128", v, 101);

    // R4 alarm
    wr(4'd1, 32'd103);
    rd(4'd2, v); chk("R4 not yet", v, 0);
    waitn(300);
    rd(4'd2, v); chk("R4 alarm pending", v, 32'h1);
    // R5 held match after clear
    wr(4'd2, 32'h1);
    waitn(100);
    rd(4'd2, v); chk("R5 stays clear", v, 0);

    // R7 power button, R9 enabled
    wr(4'd3, 32'h800);
    btn_pwr = 1'b1;
    waitn(5);
    rd(4'd2, v); chk("R7 power bit", v, 32'h800);
    chk("R9 irq high", {31'd0, irq}, 1);
    wr(4'd2, 32'h800);
    waitn(5);
    rd(4'd2, v); chk("R7 held level no reset", v, 0);
    chk("R9 irq low", {31'd0, irq}, 0);
    btn_pwr = 1'b0;

    // R7 reset button, R9 masked
    btn_rst = 1'b1;
    waitn(5);
    rd(4'd2, v); chk("R7 reset bit", v, 32'h2_0000);
    chk("R9 masked irq", {31'd0, irq}, 0);
    btn_rst = 1'b0;
    wr(4'd2, 32'h2_0000);

    // R8 generic events and ignored positions
    evt = 32'h100;
    waitn(5);
    rd(4'd2, v); chk("R8 generic bit", v, 32'h100);
    evt = 32'h0002_0901;
    waitn(5);
    rd(4'd2, v); chk("R8 fixed positions ignored", v, 32'h100);
    evt = 32'h0;
    wr(4'd2, 32'h100);
    rd(4'd2, v); chk("R6 cleared", v, 0);

    // R10 set and clear on the same edge
    evt = 32'h10;
    waitn(2);
    wr(4'd2, 32'h10);
    rd(4'd2, v); chk("R10 set wins", v, 32'h10);

    // R6 partial clear
    evt = 32'h110;
    waitn(5);
    rd(4'd2, v); chk("R6 two bits", v, 32'h110);
    wr(4'd2, 32'h10);
    rd(4'd2, v); chk("R6 partial clear", v, 32'h100);

    // R11 unmapped write/read and enable readback
    wr(4'd7, 32'hDEAD_BEEF);
    rd(4'd7, v); chk("R11 unmapped after write", v, 0);
    rd(4'd3, v); chk("R11 enable readback", v, 32'h800);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule